// File: doc/BRIEF.md
# Turbo Component Encoder Pair with Rate Selector

This block turns a frame of information bits into the coded symbol stream of a parallel concatenated turbo code. It contains two identical 16-state recursive convolutional encoders. Encoder A sees the information bits in natural order. Encoder B sees the same bits in interleaved order, which an external buffer delivers on a second input. A selector picks, for each bit time, the systematic bit and the parity symbols that the chosen code rate needs. It applies alternate puncturing at rate 1/2. After the last information bit it runs four trellis-termination steps, which drive both encoders back to the all-zero state.

The surrounding logic pulses `start` with a rate code on `rate_sel`. It then pulses `sym_en` once for each output symbol slot. On the slot enable that opens a new bit time, the block raises `bit_take`. It captures `info_a` and `info_b` in that cycle, so the feeder advances to the next bit pair after that edge. Each symbol comes out registered, one cycle after its enable. The final symbol of the codeblock is flagged with `sym_last`.

Top module: `turbo_pair_encoder`

## Requirements
- R1: After reset, and whenever no codeblock is in progress, `sym_vld` and `bit_take` stay 0 even while `sym_en` is high.
- R2: `rate_sel` is captured when `start` is high: 0 selects rate 1/2 (2 symbols per bit time), 1 selects 1/3 (3), 2 selects 1/4 (4), 3 selects 1/6 (6). Changes to `rate_sel` during a block have no effect. A block has (K_BITS+4) times that many symbols, and `sym_last` is 1 on exactly the final one.
- R3: Each encoder holds four delay cells D1..D4. Its register input is a = u xor D3 xor D4 (feedback 10011), and the cells shift a into D1. A tap vector t4..t0 gives the parity t4·a xor t3·D1 xor t2·D2 xor t1·D3 xor t0·D4.
- R4: At rate 1/3 the group is: systematic bit, parity of A with 11011, parity of B with 11011.
- R5: At rate 1/2 the group is the systematic bit followed by a single parity with taps 11011. Bit times with an even index (counted from 0 at the start of the block) keep encoder A's parity, and odd ones keep encoder B's.
- R6: At rate 1/4 the group is: systematic bit, A with 10101, A with 11111, B with 11011.
- R7: At rate 1/6 the group is: systematic bit, A with 11111, A with 11101, A with 10111, B with 11011, B with 11111.
- R8: `bit_take` is 1 exactly in a cycle where `sym_en` opens one of the first K_BITS bit times. `info_a` and `info_b` are sampled in that cycle, and their values in other cycles have no effect.
- R9: Bit times K_BITS to K_BITS+3 are termination steps. Each encoder's input equals its own D3 xor D4, and the systematic symbol is encoder A's termination input. Both registers are zero when the final symbol appears. No symbol follows until the next `start`.
- R10: Each `sym_en` during a block yields `sym_vld`=1 with the next symbol in the following cycle. No `sym_vld` appears without a `sym_en` in the cycle before.
- R11: `start` clears both encoders, the bit-time index and the symbol position, and it aborts any block in progress. It takes priority over `sym_en` in the same cycle: that cycle produces no symbol and no `bit_take`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new codeblock |
| rate_sel | input | 2 | Code rate code, captured at start |
| sym_en | input | 1 | Output symbol slot enable |
| info_a | input | 1 | Information bit in natural order |
| info_b | input | 1 | Information bit in interleaved order |
| bit_take | output | 1 | Info bits are consumed this cycle |
| sym_out | output | 1 | Coded symbol |
| sym_vld | output | 1 | `sym_out` holds a new symbol |
| sym_last | output | 1 | Final symbol of the codeblock |

## Verification
The bench drives every rate with dense and with gappy symbol enables. A rate table or tap vector that is wrong shows up as a symbol mismatch at a known position in the group. A puncturing phase that does not restart with each block, or that counts symbols instead of bit times, swaps the A and B parities on alternate groups at rate 1/2. Termination that feeds zeros instead of the feedback leaves the registers dirty, which corrupts the tail parities and the systematic tail symbols. A late `sym_last` or extra symbols after the block expose a wrong termination count. A mid-block `start` and a mid-block change of `rate_sel` check that restart clears the encoders and that the captured rate holds.

// File: rtl/turbo_pair_encoder.sv
module turbo_pair_encoder #(
  parameter int K_BITS = 1784
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] rate_sel,
  input  logic       sym_en,
  input  logic       info_a,
  input  logic       info_b,
  output logic       bit_take,
  output logic       sym_out,
  output logic       sym_vld,
  output logic       sym_last
);

  localparam int STEPS = K_BITS + 4;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [4:0] TAP_P  = 5'b11011;
  localparam logic [4:0] TAP_Q  = 5'b10101;
  localparam logic [4:0] TAP_R  = 5'b11111;
  localparam logic [4:0] TAP_S  = 5'b11101;
  localparam logic [4:0] TAP_T  = 5'b10111;

  function automatic logic parity(input logic [4:0] tap, input logic a, input logic [3:0] d);
    parity = ^(tap & {a, d[0], d[1], d[2], d[3]});
  endfunction

  logic [3:0]    st_a, st_b;
  logic [1:0]    rate_q;
  logic          busy;
  logic [CW-1:0] step;
  logic [2:0]    pos;
  logic [5:0]    grp;
  logic [5:0]    grp_new;
  logic [2:0]    n_sym;

  wire grp_start = busy & sym_en & ~start & (pos == 3'd0);
  wire in_data   = step < CW'(K_BITS);

  wire fb_a = st_a[2] ^ st_a[3];
  wire fb_b = st_b[2] ^ st_b[3];
  wire u_a  = in_data ? info_a : fb_a;
  wire u_b  = in_data ? info_b : fb_b;
  wire a_a  = u_a ^ fb_a;
  wire a_b  = u_b ^ fb_b;

  wire last_sym = busy & sym_en & ~start & (pos == n_sym - 3'd1) & (step == CW'(STEPS));

  assign bit_take = grp_start & in_data;

  always_comb begin
    case (rate_q)
      2'd0:    n_sym = 3'd2;
      2'd1:    n_sym = 3'd3;
      2'd2:    n_sym = 3'd4;
      default: n_sym = 3'd6;
    endcase
  end

  always_comb begin
    case (rate_q)
      2'd0: grp_new = {4'b0,
                       step[0] ? parity(TAP_P, a_b, st_b) : parity(TAP_P, a_a, st_a),
                       u_a};
      2'd1: grp_new = {3'b0, parity(TAP_P, a_b, st_b), parity(TAP_P, a_a, st_a), u_a};
      2'd2: grp_new = {2'b0, parity(TAP_P, a_b, st_b), parity(TAP_R, a_a, st_a),
                       parity(TAP_Q, a_a, st_a), u_a};
      default: grp_new = {parity(TAP_R, a_b, st_b), parity(TAP_P, a_b, st_b),
                          parity(TAP_T, a_a, st_a), parity(TAP_S, a_a, st_a),
                          parity(TAP_R, a_a, st_a), u_a};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_a     <= '0;
      st_b     <= '0;
      rate_q   <= '0;
      busy     <= 1'b0;
      step     <= '0;
      pos      <= '0;
      grp      <= '0;
      sym_out  <= 1'b0;
      sym_vld  <= 1'b0;
      sym_last <= 1'b0;
    end else if (start) begin
      st_a     <= '0;
      st_b     <= '0;
      rate_q   <= rate_sel;
      busy     <= 1'b1;
      step     <= '0;
      pos      <= '0;
      sym_vld  <= 1'b0;
      sym_last <= 1'b0;
    end else begin
      sym_vld  <= busy & sym_en;
      sym_last <= last_sym;
      if (busy && sym_en) begin
        if (pos == 3'd0) begin
          sym_out <= grp_new[0];
          grp     <= grp_new >> 1;
          st_a    <= {st_a[2:0], a_a};
          st_b    <= {st_b[2:0], a_b};
          step    <= step + 1'b1;
        end else begin
          sym_out <= grp[0];
          grp     <= grp >> 1;
        end
        pos <= (pos == n_sym - 3'd1) ? 3'd0 : pos + 3'd1;
        if (last_sym) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/turbo_pair_encoder_chk.sv
module turbo_pair_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sym_en,
  input logic       sym_vld,
  input logic       sym_last,
  input logic       bit_take,
  input logic [3:0] st_a,
  input logic [3:0] st_b
);

  // R10
  vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> $past(sym_en));

  // R9
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && sym_last) |-> (st_a == 4'd0 && st_b == 4'd0));

  // R9
  quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_last |=> !sym_vld);

  // R8
  take_yields_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |=> sym_vld);

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sym_vld && st_a == 4'd0 && st_b == 4'd0));

endmodule

bind turbo_pair_encoder turbo_pair_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sym_en(sym_en),
  .sym_vld(sym_vld), .sym_last(sym_last), .bit_take(bit_take),
  .st_a(st_a), .st_b(st_b)
);

// File: tb/turbo_pair_encoder_tb.sv
module turbo_pair_encoder_tb;
  localparam int K = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic sym_en = 1'b0;
  logic info_a = 1'b0;
  logic info_b = 1'b0;
  logic bit_take, sym_out, sym_vld, sym_last;

  always #5 clk = ~clk;

  turbo_pair_encoder #(.K_BITS(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
    .sym_en(sym_en), .info_a(info_a), .info_b(info_b),
    .bit_take(bit_take), .sym_out(sym_out), .sym_vld(sym_vld), .sym_last(sym_last)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string scen = "reset";

  bit bits_a[K];
  bit bits_b[K];
  bit expq[$];
  bit m_busy = 1'b0;
  int m_pos = 0;
  int m_n = 2;
  int m_rate = 0;
  int bidx = 0;
  bit exp_vld = 1'b0;
  bit exp_sym = 1'b0;
  bit exp_last = 1'b0;
  string exp_tag = "";

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s got %0d expected %0d", scen, req, got, exp);
    end
  endtask

  function automatic bit pv(input bit [4:0] t, input bit a, input bit [3:0] d);
    int acc = 0;
    if (t[4]) acc += a;
    if (t[3]) acc += d[0];
    if (t[2]) acc += d[1];
    if (t[1]) acc += d[2];
    if (t[0]) acc += d[3];
    return acc[0];
  endfunction

  // reference: R3 recursion, R4..R7 groups, R9 termination
  task automatic build(input int r);
    bit [3:0] da = 4'd0;
    bit [3:0] db = 4'd0;
    expq.delete();
    m_n = (r == 0) ? 2 : (r == 1) ? 3 : (r == 2) ? 4 : 6;
    for (int s = 0; s < K + 4; s++) begin
      bit fa = da[2] ^ da[3];
      bit fb = db[2] ^ db[3];
      bit ua = (s < K) ? bits_a[s] : fa;
      bit ub = (s < K) ? bits_b[s] : fb;
      bit aa = ua ^ fa;
      bit ab = ub ^ fb;
      expq.push_back(ua);
      case (r)
        0: expq.push_back((s % 2 == 0) ? pv(5'b11011, aa, da) : pv(5'b11011, ab, db));
        1: begin
          expq.push_back(pv(5'b11011, aa, da));
          expq.push_back(pv(5'b11011, ab, db));
        end
        2: begin
          expq.push_back(pv(5'b10101, aa, da));
          expq.push_back(pv(5'b11111, aa, da));
          expq.push_back(pv(5'b11011, ab, db));
        end
        default: begin
          expq.push_back(pv(5'b11111, aa, da));
          expq.push_back(pv(5'b11101, aa, da));
          expq.push_back(pv(5'b10111, aa, da));
          expq.push_back(pv(5'b11011, ab, db));
          expq.push_back(pv(5'b11111, ab, db));
        end
      endcase
      da = {da[2:0], aa};
      db = {db[2:0], ab};
    end
  endtask

  function automatic string sym_tag(input int p);
    if (p / m_n >= K) return "R9 tail symbol";
    case (m_rate)
      0: return "R3/R5 symbol";
      1: return "R3/R4 symbol";
      2: return "R6 symbol";
      default: return "R7 symbol";
    endcase
  endfunction

  task automatic tick(input bit en, input bit st);
    bit etake;
    @(negedge clk);
    check(sym_vld === exp_vld, "R10 sym_vld", sym_vld, exp_vld);
    if (exp_vld) begin
      check(sym_out === exp_sym, exp_tag, sym_out, exp_sym);
      check(sym_last === exp_last, "R2/R9 sym_last", sym_last, exp_last);
    end
    sym_en = en;
    start  = st;
    info_a = (bidx < K) ? bits_a[bidx] : 1'b0;
    info_b = (bidx < K) ? bits_b[bidx] : 1'b0;
    #1;
    etake = m_busy && !st && en && (m_pos % m_n == 0) && (m_pos / m_n < K);
    check(bit_take === etake, m_busy ? "R8 bit_take" : "R1 bit_take idle", bit_take, etake);
    exp_vld = 1'b0;
    if (st) begin
      m_rate = rate_sel;
      build(m_rate);
      m_busy = 1'b1;
      m_pos = 0;
      bidx = 0;
    end else if (en && m_busy) begin
      exp_vld  = 1'b1;
      exp_sym  = expq[m_pos];
      exp_last = (m_pos == expq.size() - 1);
      exp_tag  = sym_tag(m_pos);
      m_pos++;
      if (etake) bidx++;
      if (m_pos == expq.size()) m_busy = 1'b0;
    end
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < K; i++) begin
      bits_a[i] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom);
      bits_b[i] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom);
    end
  endtask

  task automatic finish_block(input bit gappy);
    int guard = 0;
    while (m_busy && guard < 2000) begin
      tick(gappy ? ($urandom % 4 != 0) : 1'b1, 1'b0);
      guard++;
    end
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
  endtask

  task automatic run_block(input int r, input bit gappy, input int mode);
    fill(mode);
    rate_sel = 2'(r);
    tick(1'b0, 1'b1);
    finish_block(gappy);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL [%s] watchdog expired got %0d expected %0d", scen, cyc, 150000);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    sym_en = 1'b1;
    #1;
    check(sym_vld === 1'b0, "R1 sym_vld in reset", sym_vld, 0);
    check(bit_take === 1'b0, "R1 bit_take in reset", bit_take, 0);
    rst_n = 1'b1;
    scen = "R1 idle enables";
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0);

    for (int r = 0; r < 4; r++) begin
      scen = $sformatf("dense rate %0d", r);
      run_block(r, 1'b0, 2);
      scen = $sformatf("gappy rate %0d", r);
      run_block(r, 1'b1, 2);
    end

    scen = "all zero R7";
    run_block(3, 1'b0, 0);
    scen = "all one R5";
    run_block(0, 1'b1, 1);
    scen = "all one R6";
    run_block(2, 1'b0, 1);

    scen = "R2 rate change ignored";
    fill(2);
    rate_sel = 2'd2;
    tick(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0);
    rate_sel = 2'd0;
    finish_block(1'b1);

    scen = "R11 restart mid block";
    fill(2);
    rate_sel = 2'd1;
    tick(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0);
    fill(2);
    rate_sel = 2'd3;
    tick(1'b1, 1'b1);
    finish_block(1'b0);

    scen = "R11 restart rate 1/2 phase";
    fill(2);
    rate_sel = 2'd0;
    tick(1'b1, 1'b1);
    for (int i = 0; i < 7; i++) tick(1'b1, 1'b0);
    fill(2);
    tick(1'b1, 1'b1);
    finish_block(1'b1);

    scen = "R1 idle after block";
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);

    summary();
  end
endmodule